// File: doc/BRIEF.md
# HDLC Serial Receive Channel

This block takes a bit-serial HDLC line and turns it into bytes for a back end. It runs on the line clock and samples one line bit per rising edge. It finds the flag octets that bound each frame and removes the zeros the transmitter inserted after runs of five ones. It treats a run of seven ones as an abort. It packs the remaining bits into octets, least significant bit first, and checks the frame check sequence. The check is CRC-16 or CRC-32, chosen by the `CRC_W` parameter.

Each payload byte is offered on `rx_data` with `rx_ready`. The back end takes the byte by pulsing `rd_ack`, and it must do so within a fixed window of clock edges. The block holds back the final two or four octets of every frame, because those octets are the check sequence and are never delivered. `valid_frame` marks the time from the first complete octet of a frame to its end. `frame_end` pulses once when the closing flag arrives. `frame_err` reports a bad check sequence, a frame length that is not a whole number of octets, an abort, or a byte the back end failed to take.

Top module: `hdlc_rx_chan`

## Requirements
- R1: While `rst_n` is low and after it is released with an idle line of ones, `rx_ready`, `valid_frame`, `frame_err` and `frame_end` are all 0.
- R2: The flag is 01111110. The bits between two flags are packed into bytes, with the first received bit as bit 0. The bytes are delivered in order. The last CRC_W/8 octets are consumed by the check and are never delivered.
- R3: Inside a frame, a 0 that follows five consecutive 1s is removed and adds no bit to the data.
- R4: At the closing flag, `frame_end` pulses for one cycle. `frame_err` is 0 if the CRC register holds the good residue: 0xF0B8 for the reflected CRC-16 (polynomial 0x8408, preset all ones, complement sent low byte first), or 0xDEBB20E3 for the reflected CRC-32 (polynomial 0xEDB88320). Otherwise `frame_err` is 1.
- R5: A frame whose data bit count is not a multiple of 8 ends with `frame_err` 1.
- R6: Seven consecutive 1s abort an open frame. `valid_frame` drops, `frame_err` is set, and no `frame_end` is given. All bits are then ignored until the next flag.
- R7: `valid_frame` rises when the first octet after the opening flag is complete. It is 1 when the first byte is offered, and it is 0 from the closing flag onwards.
- R8: An `rd_ack` sampled at any of the RD_WIN (7) rising edges after `rx_ready` rises takes the byte and clears `rx_ready`. If no ack arrives, `rx_ready` drops at the RD_WIN-th edge. If `valid_frame` is 1 at that edge, `frame_err` is set and stays set while `valid_frame` is active.
- R9: `frame_err` stays set until the first octet of the next frame completes, and it is cleared at that point.
- R10: With CRC_W = 32, the CRC-32 check of R4 is used and four octets are withheld.
- R11: Back-to-back flags do not produce `frame_end`. A single flag may close one frame and open the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; one line bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Serial line data |
| rd_ack | input | 1 | Back end takes the offered byte |
| rx_data | output | 8 | Offered payload byte |
| rx_ready | output | 1 | A byte is offered |
| valid_frame | output | 1 | A frame with at least one octet is in progress |
| frame_err | output | 1 | Error of the current or last frame |
| frame_end | output | 1 | One-cycle pulse at a closing flag |

## Verification
A line bit reaches the frame logic eight edges after it is sampled. Its effect on `valid_frame`, `frame_err` or `frame_end` appears one edge after that. A completed octet that releases a byte raises `rx_ready` one edge after the octet completes. The bench drives line bits and acks on falling edges, and a monitor samples every output on falling edges, so each result is read half a cycle after the edge that sets it. Each frame is followed by 24 idle cycles before its checks run. That covers the eight-edge pipeline plus the longest read window. Acks are placed a counted number of edges after `rx_ready` rises, which tests the last accepted edge (the seventh) and the first late one (the eighth).

// File: rtl/hdlc_rx_pkg.sv
// Shared types and CRC constants for the serial receive channel.
// Assumes reflected (LSB-first) CRC arithmetic on the line bit order.
package hdlc_rx_pkg;

    // Classification of one line bit as it moves through the deframer
    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,   // discarded: stuffed zero, flag/abort body, idle
        CL_DATA  = 2'd1,   // frame data bit
        CL_FLAG  = 2'd2,   // last bit of a flag
        CL_ABORT = 2'd3    // seventh consecutive one
    } bit_class_t;

    localparam int FLAG_LEN = 8;

    function automatic logic [31:0] fcs_poly(input int w);
        return (w == 32) ? 32'hEDB8_8320 : 32'h0000_8408;
    endfunction

    function automatic logic [31:0] fcs_residue(input int w);
        return (w == 32) ? 32'hDEBB_20E3 : 32'h0000_F0B8;
    endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
// Classifies each line bit (data, stuffed zero, flag end, abort).
// Delays the result by FLAG_LEN stages, so that a flag or abort can erase
// the bits before it that belong to its own pattern.
// Assumes one line bit per clock edge.
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = FLAG_LEN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_bit,
    output bit_class_t out_cls,
    output logic       out_bit
);

    logic [2:0]       ones;
    bit_class_t       in_cls;
    bit_class_t       cls_pipe [DEPTH];
    logic [DEPTH-1:0] bit_pipe;

    // Classify the incoming bit from the count of ones before it
    always_comb begin
        if (line_bit) begin
            if (ones == 3'd6)      in_cls = CL_ABORT;
            else if (ones == 3'd7) in_cls = CL_NONE;
            else                   in_cls = CL_DATA;
        end else begin
            if (ones == 3'd6)      in_cls = CL_FLAG;
            else if (ones == 3'd5) in_cls = CL_NONE;
            else                   in_cls = CL_DATA;
        end
    end

    // Count consecutive ones, saturating at seven
    always_ff @(posedge clk) begin
        if (!rst_n)         ones <= '0;
        else if (!line_bit) ones <= '0;
        else if (ones != 3'd7) ones <= ones + 3'd1;
    end

    // Shift the classes along; a flag erases 7 older stages, an abort 6
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_pipe <= '0;
            for (int i = 0; i < DEPTH; i++) cls_pipe[i] <= CL_NONE;
        end else begin
            bit_pipe    <= {bit_pipe[DEPTH-2:0], line_bit};
            cls_pipe[0] <= in_cls;
            for (int i = 1; i < DEPTH; i++) begin
                if (in_cls == CL_FLAG || (in_cls == CL_ABORT && i < DEPTH - 1))
                    cls_pipe[i] <= CL_NONE;
                else
                    cls_pipe[i] <= cls_pipe[i-1];
            end
        end
    end

    assign out_cls = cls_pipe[DEPTH-1];
    assign out_bit = bit_pipe[DEPTH-1];

endmodule

// File: rtl/hdlc_rx_fcs.sv
// Bit-serial reflected CRC over the data bits of a frame. The register is
// preset at every flag or abort. good is 1 when the register holds the
// residue of an intact frame. Assumes CRC_W is 16 or 32.
module hdlc_rx_fcs
    import hdlc_rx_pkg::*;
#(
    parameter int CRC_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic din,
    output logic good
);

    localparam logic [31:0]      POLY32  = fcs_poly(CRC_W);
    localparam logic [31:0]      RESID32 = fcs_residue(CRC_W);
    localparam logic [CRC_W-1:0] POLY    = POLY32[CRC_W-1:0];
    localparam logic [CRC_W-1:0] RESID   = RESID32[CRC_W-1:0];

    logic [CRC_W-1:0] crc;

    // One LFSR step per data bit, preset on frame boundaries
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= '1;
        else if (en)       crc <= (crc >> 1) ^ ({CRC_W{crc[0] ^ din}} & POLY);
    end

    assign good = (crc == RESID);

endmodule

// File: rtl/hdlc_rx_framer.sv
// Frame state: hunts for a flag, packs data bits into octets and holds the
// last CRC_W/8 octets back, because they may be the check sequence.
// Releases older octets to the hand-off stage. Drives the frame status.
// Assumes classified bits from the deframer.
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
#(
    parameter int CRC_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  bit_class_t cls,
    input  logic       cls_bit,
    input  logic       fcs_good,
    input  logic       miss,
    output logic       fcs_clr,
    output logic       fcs_en,
    output logic       push,
    output logic [7:0] push_data,
    output logic       valid_frame,
    output logic       frame_err,
    output logic       frame_end
);

    localparam int NF = CRC_W / 8;
    localparam int HW = $clog2(NF + 1);

    logic          open;
    logic [2:0]    bit_idx;
    logic [7:0]    sreg;
    logic          got_bits;
    logic [HW-1:0] hcnt;
    logic          rel_any;
    logic [7:0]    hold [NF];
    logic          oct_done;
    logic [7:0]    byte_new;
    logic          bad;

    assign fcs_clr  = (cls == CL_FLAG) || (cls == CL_ABORT);
    assign fcs_en   = open && (cls == CL_DATA);
    assign oct_done = open && (cls == CL_DATA) && (bit_idx == 3'd7);
    assign byte_new = {cls_bit, sreg[7:1]};
    assign bad      = (bit_idx != 3'd0) || !rel_any || !fcs_good;

    // Hold line of the most recent octets, newest at index 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) hold[i] <= '0;
        end else if (oct_done) begin
            hold[0] <= byte_new;
            for (int i = 1; i < NF; i++) hold[i] <= hold[i-1];
        end
    end

    // Frame state machine, octet assembly, release and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open        <= 1'b0;
            bit_idx     <= '0;
            sreg        <= '0;
            got_bits    <= 1'b0;
            hcnt        <= '0;
            rel_any     <= 1'b0;
            valid_frame <= 1'b0;
            frame_err   <= 1'b0;
            frame_end   <= 1'b0;
            push        <= 1'b0;
            push_data   <= '0;
        end else begin
            frame_end <= 1'b0;
            push      <= 1'b0;
            unique case (cls)
                CL_FLAG: begin
                    if (open && got_bits) begin
                        frame_end <= 1'b1;
                        if (bad) frame_err <= 1'b1;
                    end
                    open        <= 1'b1;
                    valid_frame <= 1'b0;
                    bit_idx     <= '0;
                    got_bits    <= 1'b0;
                    hcnt        <= '0;
                    rel_any     <= 1'b0;
                end
                CL_ABORT: begin
                    if (open && got_bits) frame_err <= 1'b1;
                    open        <= 1'b0;
                    valid_frame <= 1'b0;
                    bit_idx     <= '0;
                    got_bits    <= 1'b0;
                    hcnt        <= '0;
                    rel_any     <= 1'b0;
                end
                CL_DATA: begin
                    if (open) begin
                        got_bits <= 1'b1;
                        bit_idx  <= bit_idx + 3'd1;
                        sreg     <= byte_new;
                        if (bit_idx == 3'd7) begin
                            if (!valid_frame) begin
                                valid_frame <= 1'b1;
                                frame_err   <= 1'b0;
                            end
                            if (hcnt == HW'(NF)) begin
                                push      <= 1'b1;
                                push_data <= hold[NF-1];
                                rel_any   <= 1'b1;
                            end else begin
                                hcnt <= hcnt + 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
            if (miss && valid_frame) frame_err <= 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_rx_handoff.sv
// Offers each released byte to the back end. The byte is taken by an ack
// within WIN edges. If no ack comes, the offer is withdrawn and miss is
// raised for one cycle. Assumes offers are at least WIN+1 cycles apart.
module hdlc_rx_handoff #(
    parameter int WIN = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       rd_ack,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       miss
);

    localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;

    logic [WW-1:0] wcnt;

    assign miss = rx_ready && !rd_ack && (wcnt == WW'(WIN - 1));

    // Offer register and read-window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ready <= 1'b0;
            rx_data  <= '0;
            wcnt     <= '0;
        end else if (push) begin
            rx_ready <= 1'b1;
            rx_data  <= push_data;
            wcnt     <= '0;
        end else if (rx_ready) begin
            if (rd_ack || miss) rx_ready <= 1'b0;
            else                wcnt     <= wcnt + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_rx_chan.sv
// HDLC serial receive channel top: deframer, CRC checker, framer and
// byte hand-off. Runs entirely on the line clock. CRC_W selects
// CRC-16 or CRC-32.
module hdlc_rx_chan #(
    parameter int CRC_W  = 16,
    parameter int RD_WIN = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_bit,
    input  logic       rd_ack,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       valid_frame,
    output logic       frame_err,
    output logic       frame_end
);
    import hdlc_rx_pkg::*;

    bit_class_t cls;
    logic       cls_bit;
    logic       fcs_good;
    logic       fcs_clr;
    logic       fcs_en;
    logic       push;
    logic [7:0] push_data;
    logic       miss;

    hdlc_rx_deframer #(.DEPTH(FLAG_LEN)) deframer_i (
        .clk(clk), .rst_n(rst_n), .line_bit(rx_bit),
        .out_cls(cls), .out_bit(cls_bit)
    );

    hdlc_rx_fcs #(.CRC_W(CRC_W)) fcs_i (
        .clk(clk), .rst_n(rst_n), .clr(fcs_clr), .en(fcs_en),
        .din(cls_bit), .good(fcs_good)
    );

    hdlc_rx_framer #(.CRC_W(CRC_W)) framer_i (
        .clk(clk), .rst_n(rst_n), .cls(cls), .cls_bit(cls_bit),
        .fcs_good(fcs_good), .miss(miss), .fcs_clr(fcs_clr),
        .fcs_en(fcs_en), .push(push), .push_data(push_data),
        .valid_frame(valid_frame), .frame_err(frame_err),
        .frame_end(frame_end)
    );

    hdlc_rx_handoff #(.WIN(RD_WIN)) handoff_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .rd_ack(rd_ack), .rx_data(rx_data), .rx_ready(rx_ready),
        .miss(miss)
    );

endmodule

// File: rtl/hdlc_rx_chan_chk.sv
// Property checker for the receive channel, bound to the top module.
// Watches only top-level ports.
module hdlc_rx_chan_chk #(
    parameter int WIN = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_ack,
    input logic [7:0] rx_data,
    input logic       rx_ready,
    input logic       valid_frame,
    input logic       frame_err,
    input logic       frame_end
);

    logic [7:0] run;

    // Count consecutive cycles with a byte on offer
    always_ff @(posedge clk) begin
        if (!rst_n)        run <= '0;
        else if (rx_ready) run <= run + 8'd1;
        else               run <= '0;
    end

    AST_READY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (run < WIN)); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rd_ack) |=> !rx_ready); // R8

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_ack) |=> (!rx_ready || $stable(rx_data))); // R8

    AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end); // R4

    AST_END_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !valid_frame); // R7

    AST_ERR_CLEAR_AT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_err) |-> $rose(valid_frame)); // R9

endmodule

bind hdlc_rx_chan hdlc_rx_chan_chk #(.WIN(RD_WIN)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_ack(rd_ack), .rx_data(rx_data),
    .rx_ready(rx_ready), .valid_frame(valid_frame),
    .frame_err(frame_err), .frame_end(frame_end)
);

// File: tb/hdlc_rx_chan_tb_top.sv
// Directed bench for the receive channel. It has one task per scenario.
// A falling-edge monitor acks bytes after a set delay and records the results.
module hdlc_rx_chan_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, bit16, bit32, rd_ack, sel32;
    logic [7:0] d16, d32;
    logic       r16, r32, v16, v32, e16, e32, f16, f32;
    logic [7:0] m_data;
    logic       m_ready, m_valid, m_err, m_end;

    hdlc_rx_chan #(.CRC_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(bit16), .rd_ack(rd_ack),
        .rx_data(d16), .rx_ready(r16), .valid_frame(v16),
        .frame_err(e16), .frame_end(f16)
    );

    hdlc_rx_chan #(.CRC_W(32)) dut32_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(bit32), .rd_ack(rd_ack),
        .rx_data(d32), .rx_ready(r32), .valid_frame(v32),
        .frame_err(e32), .frame_end(f32)
    );

    always_comb begin
        m_data  = sel32 ? d32 : d16;
        m_ready = sel32 ? r32 : r16;
        m_valid = sel32 ? v32 : v16;
        m_err   = sel32 ? e32 : e16;
        m_end   = sel32 ? f32 : f16;
    end

    int         checks = 0, fails = 0;
    int         ack_delay = 2, wcnt = 0;
    logic [7:0] got [$];
    int         ends = 0, last_end_err = -1;
    bit         saw_valid = 0, err_in_valid = 0, valid_at_first = 0;
    logic       txq [$];
    int         tx_ones = 0;

    // Monitor: ack after ack_delay falling edges of an offer, record events
    initial begin
        rd_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rd_ack) rd_ack = 1'b0;
            else if (m_ready) begin
                wcnt++;
                if (wcnt == ack_delay) begin
                    if (got.size() == 0) valid_at_first = m_valid;
                    got.push_back(m_data);
                    rd_ack = 1'b1;
                    wcnt   = 0;
                end
            end else wcnt = 0;
            if (m_end) begin ends++; last_end_err = m_err; end
            if (m_valid) saw_valid = 1;
            if (m_valid && m_err) err_in_valid = 1;
        end
    end

    // Watchdog: an overlong run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): got %0d expected %0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_bytes(input string tag, input logic [7:0] exp [$]);
        int bad_at = -1;
        checks++;
        if (got.size() != exp.size()) bad_at = 0;
        else foreach (exp[i]) if (bad_at < 0 && got[i] != exp[i]) bad_at = i;
        if (bad_at >= 0) begin
            fails++;
            $display("FAIL %s: got %0d bytes (first %0h) expected %0d bytes (first %0h)",
                     tag, got.size(), (got.size() > 0) ? got[0] : 8'h0,
                     exp.size(), (exp.size() > 0) ? exp[0] : 8'h0);
        end
    endtask

    task automatic mon_clear();
        got.delete();
        ends = 0; last_end_err = -1;
        saw_valid = 0; err_in_valid = 0; valid_at_first = 0;
    endtask

    function automatic logic [31:0] calc_fcs(input logic [7:0] p [$], input int w);
        logic [31:0] c;
        logic        fb;
        c = (w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        foreach (p[i]) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[0] ^ p[i][b];
                c  = c >> 1;
                if (fb) c = c ^ ((w == 32) ? 32'hEDB8_8320 : 32'h0000_8408);
            end
        end
        return ~c;
    endfunction

    task automatic add_flag();
        txq.push_back(1'b0);
        for (int i = 0; i < 6; i++) txq.push_back(1'b1);
        txq.push_back(1'b0);
        tx_ones = 0;
    endtask

    task automatic add_bit(input logic b);
        txq.push_back(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin txq.push_back(1'b0); tx_ones = 0; end
        end else tx_ones = 0;
    endtask

    task automatic add_byte(input logic [7:0] v);
        for (int b = 0; b < 8; b++) add_bit(v[b]);
    endtask

    task automatic add_body(input logic [7:0] p [$], input int w, input bit corrupt);
        logic [31:0] f;
        logic [7:0]  fb;
        foreach (p[i]) add_byte(p[i]);
        f = calc_fcs(p, w);
        for (int k = 0; k < w / 8; k++) begin
            fb = f[8*k +: 8];
            if (k == 0 && corrupt) fb = fb ^ 8'h01;
            add_byte(fb);
        end
    endtask

    task automatic play();
        foreach (txq[i]) begin
            @(negedge clk);
            if (sel32) bit32 = txq[i]; else bit16 = txq[i];
        end
        txq.delete();
        @(negedge clk);
        bit16 = 1'b1; bit32 = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ready in reset", r16, 0);
        chk("R1 valid in reset", v16, 0);
        chk("R1 err in reset", e16 | f16, 0);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk("R1 idle after reset", {r16, v16, e16, f16, r32, v32, e32, f32}, 0);
    endtask

    task automatic t_good16();
        logic [7:0] p [$] = '{8'hA5, 8'h3C, 8'h01, 8'h80};
        mon_clear();
        add_flag(); add_flag(); add_flag();
        add_body(p, 16, 0); add_flag();
        play();
        chk_bytes("R2 payload order, FCS withheld", p);
        chk("R11 repeated flags give one end", ends, 1);
        chk("R4 good FCS no error", last_end_err, 0);
        chk("R7 valid at first byte", valid_at_first, 1);
        chk("R7 valid low after close", m_valid, 0);
    endtask

    task automatic t_stuffing();
        logic [7:0] p [$] = '{8'hFF, 8'hFF, 8'h7E, 8'hF8, 8'h1F};
        mon_clear();
        add_flag(); add_body(p, 16, 0); add_flag();
        play();
        chk_bytes("R3 stuffed zeros removed", p);
        chk("R3 stuffed frame good", last_end_err, 0);
    endtask

    task automatic t_bad_fcs();
        logic [7:0] p [$] = '{8'h12, 8'h34, 8'h56};
        mon_clear();
        add_flag(); add_body(p, 16, 1); add_flag();
        play();
        chk("R4 FCS mismatch end", ends, 1);
        chk("R4 FCS mismatch error", last_end_err, 1);
    endtask

    task automatic t_misaligned();
        logic [7:0] p [$] = '{8'h21, 8'h43, 8'h65};
        mon_clear();
        add_flag(); add_body(p, 16, 0);
        add_bit(1'b0); add_bit(1'b1); add_bit(1'b0);
        add_flag();
        play();
        chk("R5 misaligned error", last_end_err, 1);
    endtask

    task automatic t_abort();
        logic [7:0] p [$] = '{8'h11, 8'h22, 8'h33, 8'h44};
        logic [7:0] q [$] = '{8'h9A, 8'hBC};
        mon_clear();
        add_flag();
        foreach (p[i]) add_byte(p[i]);
        for (int i = 0; i < 8; i++) txq.push_back(1'b1);
        play();
        chk("R6 abort gives no end", ends, 0);
        chk("R6 abort sets error", m_err, 1);
        chk("R6 abort drops valid", m_valid, 0);
        mon_clear();
        add_byte(8'h55); add_byte(8'h0F);
        add_flag(); add_body(q, 16, 0); add_flag();
        play();
        chk_bytes("R6 bits before flag ignored", q);
        chk("R9 error cleared by next frame", last_end_err, 0);
    endtask

    task automatic t_window();
        logic [7:0] p [$] = '{8'hC3, 8'h5A, 8'hE7, 8'h18};
        mon_clear();
        ack_delay = 7;
        add_flag(); add_body(p, 16, 0); add_flag();
        play();
        chk_bytes("R8 ack at seventh edge taken", p);
        chk("R8 seventh edge no error", last_end_err, 0);
        mon_clear();
        ack_delay = 8;
        add_flag(); add_body(p, 16, 0); add_flag();
        play();
        chk("R8 late ack drops byte", got.size(), 0);
        chk("R8 miss error during valid", err_in_valid, 1);
        chk("R8 miss error held to end", last_end_err, 1);
        ack_delay = 2;
    endtask

    task automatic t_shared_flag();
        logic [7:0] a [$] = '{8'h01, 8'h02, 8'h03};
        logic [7:0] b [$] = '{8'hF0, 8'h0F};
        logic [7:0] ab [$];
        ab = {a, b};
        mon_clear();
        add_flag(); add_body(a, 16, 0); add_flag(); add_body(b, 16, 0); add_flag();
        play();
        chk("R11 shared flag two ends", ends, 2);
        chk_bytes("R11 shared flag payloads", ab);
        chk("R11 second frame good", last_end_err, 0);
    endtask

    task automatic t_crc32();
        logic [7:0] p [$] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h42};
        sel32 = 1'b1;
        mon_clear();
        add_flag(); add_body(p, 32, 0); add_flag();
        play();
        chk_bytes("R10 CRC-32 four octets withheld", p);
        chk("R10 CRC-32 good", last_end_err, 0);
        mon_clear();
        add_flag(); add_body(p, 32, 1); add_flag();
        play();
        chk("R10 CRC-32 mismatch error", last_end_err, 1);
        sel32 = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; bit16 = 1'b1; bit32 = 1'b1; sel32 = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_good16();
        t_stuffing();
        t_bad_fcs();
        t_misaligned();
        t_abort();
        t_window();
        t_shared_flag();
        t_crc32();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule